// File: doc/BRIEF.md
# Selectable-Timebase Watchdog Counter

This block is a down-counting watchdog programmed through four byte-wide registers on a simple address/data write port with a combinational read path. Software picks a timebase (one-second or one-minute ticks), chooses which expiry pulses are allowed, and writes a reload value. The tick generator is built in. It divides the system clock by a parameterised number of cycles per second, and the second count by the number of seconds per minute.

The count is loaded when the low byte of the value is written. The high byte stored earlier supplies the upper bits, so software writes the high byte first whenever it changes. The same write serves as the keep-alive: the count restarts from the new value and the tick phase is cleared. Loading zero stops the watchdog. When the count reaches zero, a sticky timeout flag is raised. Each enabled output then emits a pulse lasting a fixed number of clocks. The counter is 8 or 16 bits wide, chosen by a parameter.

Top module: `wdt_unit_timer`

## Requirements
- R1: After reset the configuration reads 0x00, both count bytes read 0x00, the control register reads 0x00 and all three pulse outputs and the timeout flag are low.
- R2: The configuration register at address 0x72 reads back every written 8-bit value. A read of any address other than 0x71 to 0x74 returns 0x00.
- R3: A write to address 0x73 loads the counter with {held high byte, written byte}, where the high byte is the last value written to 0x74. Address 0x73 reads the live count bits 7:0 and 0x74 reads bits 15:8.
- R4: With configuration bit 7 set (seconds), a running count decrements once every TICKS_PER_SEC clocks. The first decrement falls on the TICKS_PER_SEC-th clock edge after the loading edge.
- R5: With configuration bit 7 clear (minutes), a running count decrements once every SEC_PER_MIN*TICKS_PER_SEC clocks, counted from the loading edge.
- R6: Loading a value of zero stops the watchdog: the count stays zero and no timeout follows.
- R7: Loading a nonzero value while running restarts the count from that value and restarts the tick phase, so expiry moves to a full period count after the reload.
- R8: On the clock edge where the count goes from 1 to 0, control register bit 0 (the timeout flag, also on timeout_flag_o) becomes 1. It stays 1 until cleared.
- R9: Writing a byte with bit 0 set to address 0x71 clears the timeout flag. A write with bit 0 clear has no effect. If an expiry falls on the same edge as a clear, the flag ends up set.
- R10: On expiry, kbd_rst_o pulses if configuration bit 6 is set, tmo_out_o pulses if bit 5 is set, and pgood_trip_o pulses if bit 4 is set. Each pulse is high for exactly PULSE_LEN clocks, starting with the expiry edge. A disabled output stays low.
- R11: With CNT_WIDTH = 8, writes to 0x74 are ignored, 0x74 reads 0x00, and a load uses the written low byte only.
- R12: A load that falls on the same edge as a selected tick wins: the count takes the loaded value with no decrement, and the next decrement comes a full tick period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one clock |
| bus_addr | input | 8 | Register address for write and read |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| timeout_flag_o | output | 1 | Sticky timeout status (control bit 0) |
| kbd_rst_o | output | 1 | Keyboard-reset pulse on expiry |
| tmo_out_o | output | 1 | General timeout output pulse on expiry |
| pgood_trip_o | output | 1 | Power-good trip pulse on expiry |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is a keep-alive reload and a tick. The bench times the low-byte write so that it lands exactly TICKS_PER_SEC edges after a previous load. It then expects the loaded value to hold for a full period before the first decrement. The second pair is an expiry and a flag-clear write. The clear is placed on the very edge where a count of one expires, and the bench expects the flag to read 1 afterwards. A later standalone clear is expected to drop it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [7:0] ADDR_CTRL   = 8'h71;
  localparam logic [7:0] ADDR_CFG    = 8'h72;
  localparam logic [7:0] ADDR_CNT_LO = 8'h73;
  localparam logic [7:0] ADDR_CNT_HI = 8'h74;

  localparam int CFG_SEC_BIT = 7;
  localparam int CFG_KBD_BIT = 6;
  localparam int CFG_TMO_BIT = 5;
  localparam int CFG_PWR_BIT = 4;

  localparam int N_PULSE = 3;

  // index of each pulse channel in the enable vector
  typedef enum int {
    CH_KBD = 0,
    CH_TMO = 1,
    CH_PWR = 2
  } pulse_ch_e;

  // reload value from held high byte and written low byte
  function automatic logic [15:0] build_reload(input logic [7:0] hi,
                                               input logic [7:0] lo,
                                               input bit wide);
    return wide ? {hi, lo} : {8'h00, lo};
  endfunction

  // next count for one cycle of the counter
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic load,
                                             input logic [15:0] ldv,
                                             input logic tick);
    if (load)                    return ldv;
    else if (tick && cur != '0)  return cur - 16'd1;
    else                         return cur;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_PER_MIN   = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick_sec,
  output logic tick_min
);
  localparam int DW = $clog2(TICKS_PER_SEC + 1);
  localparam int MW = $clog2(SEC_PER_MIN + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(TICKS_PER_SEC - 1);
  localparam logic [MW-1:0] SEC_LAST = MW'(SEC_PER_MIN - 1);

  logic [DW-1:0] div_q;
  logic [MW-1:0] sec_q;

  assign tick_sec = (div_q == DIV_LAST);
  assign tick_min = tick_sec && (sec_q == SEC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sec_q <= '0;
    end else if (restart) begin
      div_q <= '0;
      sec_q <= '0;
    end else if (tick_sec) begin
      div_q <= '0;
      sec_q <= tick_min ? '0 : sec_q + MW'(1);
    end else begin
      div_q <= div_q + DW'(1);
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] cnt_q,
  output logic          expire_evt
);
  import wdt_pkg::*;

  logic [15:0] cnt_w;
  logic [15:0] nxt_w;

  assign cnt_w      = 16'(cnt_q);
  assign nxt_w      = next_count(cnt_w, load_stb, 16'(load_val), tick);
  assign expire_evt = !load_stb && tick && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_w[CW-1:0];
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic en,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left_q <= '0;
    else if (fire && en) left_q <= PW'(PULSE_LEN);
    else if (pulse_o)    left_q <= left_q - PW'(1);
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [7:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic [CW-1:0] cnt_q,
  input  logic          expire_evt,
  output logic [7:0]    cfg_q,
  output logic [7:0]    msb_q,
  output logic          sts_q,
  output logic          load_stb,
  output logic          clr_stb,
  output logic [7:0]    bus_rdata
);
  import wdt_pkg::*;

  logic        wr_cfg;
  logic [15:0] cnt_w;

  assign wr_cfg   = bus_we && (bus_addr == ADDR_CFG);
  assign load_stb = bus_we && (bus_addr == ADDR_CNT_LO);
  assign clr_stb  = bus_we && (bus_addr == ADDR_CTRL) && bus_wdata[0];
  assign cnt_w    = 16'(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= bus_wdata;
  end

  // expiry beats a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sts_q <= 1'b0;
    else if (expire_evt) sts_q <= 1'b1;
    else if (clr_stb)    sts_q <= 1'b0;
  end

  generate
    if (CW > 8) begin : g_hi
      logic wr_hi;
      assign wr_hi = bus_we && (bus_addr == ADDR_CNT_HI);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     msb_q <= '0;
        else if (wr_hi) msb_q <= bus_wdata;
      end
    end else begin : g_no_hi
      assign msb_q = 8'h00;
    end
  endgenerate

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL:   bus_rdata = {7'b0, sts_q};
      ADDR_CFG:    bus_rdata = cfg_q;
      ADDR_CNT_LO: bus_rdata = cnt_w[7:0];
      ADDR_CNT_HI: bus_rdata = cnt_w[15:8];
      default:     bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer #(
  parameter int CNT_WIDTH     = 16,
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_PER_MIN   = 60,
  parameter int PULSE_LEN     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       timeout_flag_o,
  output logic       kbd_rst_o,
  output logic       tmo_out_o,
  output logic       pgood_trip_o
);
  import wdt_pkg::*;

  localparam bit WIDE = (CNT_WIDTH > 8);

  logic [7:0]           cfg_q;
  logic [7:0]           msb_q;
  logic                 sts_q;
  logic                 load_stb;
  logic                 clr_stb;
  logic [CNT_WIDTH-1:0] cnt_q;
  logic [CNT_WIDTH-1:0] load_val;
  logic [15:0]          reload_w;
  logic                 tick_sec;
  logic                 tick_min;
  logic                 tick_sel;
  logic                 expire_evt;
  logic [N_PULSE-1:0]   pulse_en;
  logic [N_PULSE-1:0]   pulse_vec;

  wdt_regs #(.CW(CNT_WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_q(cnt_q), .expire_evt(expire_evt),
    .cfg_q(cfg_q), .msb_q(msb_q), .sts_q(sts_q), .load_stb(load_stb),
    .clr_stb(clr_stb), .bus_rdata(bus_rdata)
  );

  assign reload_w = build_reload(msb_q, bus_wdata, WIDE);
  assign load_val = reload_w[CNT_WIDTH-1:0];

  wdt_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(load_stb),
    .tick_sec(tick_sec), .tick_min(tick_min)
  );

  assign tick_sel = cfg_q[CFG_SEC_BIT] ? tick_sec : tick_min;

  wdt_counter #(.CW(CNT_WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(load_val),
    .tick(tick_sel), .cnt_q(cnt_q), .expire_evt(expire_evt)
  );

  assign pulse_en[CH_KBD] = cfg_q[CFG_KBD_BIT];
  assign pulse_en[CH_TMO] = cfg_q[CFG_TMO_BIT];
  assign pulse_en[CH_PWR] = cfg_q[CFG_PWR_BIT];

  generate
    for (genvar i = 0; i < N_PULSE; i++) begin : g_pulse
      wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire_evt), .en(pulse_en[i]),
        .pulse_o(pulse_vec[i])
      );
    end
  endgenerate

  assign kbd_rst_o      = pulse_vec[CH_KBD];
  assign tmo_out_o      = pulse_vec[CH_TMO];
  assign pgood_trip_o   = pulse_vec[CH_PWR];
  assign timeout_flag_o = sts_q;
endmodule

// File: rtl/wdt_unit_timer_chk.sv
module wdt_unit_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_stb,
  input logic [CW-1:0] load_val,
  input logic          tick_sel,
  input logic [CW-1:0] cnt_q,
  input logic          expire_evt,
  input logic          sts_q,
  input logic          clr_stb,
  input logic          kbd_en,
  input logic          kbd_rst_o
);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> cnt_q == $past(load_val));

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && tick_sel && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1));

  p_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && cnt_q == '0) |=> cnt_q == '0);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> sts_q);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !clr_stb) |=> sts_q);

  p_kbd_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_rst_o) |-> ($past(expire_evt) && $past(kbd_en)));

  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && tick_sel) |=> cnt_q == $past(load_val));
endmodule

bind wdt_unit_timer wdt_unit_timer_chk #(.CW(CNT_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_val(load_val),
  .tick_sel(tick_sel), .cnt_q(cnt_q), .expire_evt(expire_evt),
  .sts_q(sts_q), .clr_stb(clr_stb), .kbd_en(cfg_q[6]), .kbd_rst_o(kbd_rst_o)
);

// File: tb/wdt_unit_timer_tb.sv
module wdt_unit_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 4;
  localparam int SM = 60;
  localparam int PL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] rd16, rd8;
  logic flag16, kbd16, tmo16, pwr16;
  logic flag8, kbd8, tmo8, pwr8;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_unit_timer #(.CNT_WIDTH(16), .TICKS_PER_SEC(T), .SEC_PER_MIN(SM), .PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd16), .timeout_flag_o(flag16), .kbd_rst_o(kbd16), .tmo_out_o(tmo16),
    .pgood_trip_o(pwr16));

  wdt_unit_timer #(.CNT_WIDTH(8), .TICKS_PER_SEC(T), .SEC_PER_MIN(SM), .PULSE_LEN(PL)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd8), .timeout_flag_o(flag8), .kbd_rst_o(kbd8), .tmo_out_o(tmo8),
    .pgood_trip_o(pwr8));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v16, output logic [7:0] v8);
    bus_addr = a;
    #1;
    v16 = rd16; v8 = rd8;
  endtask

  task automatic load(input int v);
    wr(8'h74, 8'(v >> 8));
    wr(8'h73, 8'(v));
  endtask

  task automatic count16(output int c);
    logic [7:0] lo, hi, x;
    rd(8'h73, lo, x);
    rd(8'h74, hi, x);
    c = {hi, lo};
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired before the bench finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h72, a, b); check("R1 cfg", a, 8'h00);
    count16(c);      check("R1 count", c, 0);
    rd(8'h71, a, b); check("R1 ctrl", a, 8'h00);
    check("R1 outputs", {flag16, kbd16, tmo16, pwr16}, 0);

    // R2 cfg readback sweep and unmapped addresses
    for (int v = 0; v < 256; v++) begin
      wr(8'h72, 8'(v));
      rd(8'h72, a, b); check("R2 cfg readback", a, v);
    end
    for (int ad = 8'h6e; ad < 8'h78; ad++) begin
      if (ad < 8'h71 || ad > 8'h74) begin
        rd(8'(ad), a, b); check("R2 unmapped", a, 0);
      end
    end

    // R4 R8 R10 seconds sweep over all enable combinations
    for (int combo = 0; combo < 8; combo++) begin
      int n;
      n = combo % 4 + 1;
      wr(8'h71, 8'h01);
      wr(8'h72, 8'(8'h80 | (combo << 4)));
      load(n);
      for (int k = 0; k < n * T; k++) begin
        count16(c); check("R4 seconds count", c, n - k / T);
        check("R8 flag before expiry", flag16, 0);
        @(negedge clk);
      end
      count16(c); check("R8 count zero", c, 0);
      check("R8 flag set", flag16, 1);
      for (int p = 0; p < PL; p++) begin
        check("R10 kbd pulse", kbd16, (combo >> 2) & 1);
        check("R10 tmo pulse", tmo16, (combo >> 1) & 1);
        check("R10 pgood pulse", pwr16, combo & 1);
        @(negedge clk);
      end
      check("R10 pulses end", {kbd16, tmo16, pwr16}, 0);
    end

    // R9 clear semantics
    wr(8'h71, 8'h00); check("R9 write zero keeps flag", flag16, 1);
    wr(8'h71, 8'h01); check("R9 clear", flag16, 0);
    rd(8'h71, a, b);  check("R9 ctrl read", a, 0);

    // R5 minutes mode
    wr(8'h72, 8'h40);
    load(2);
    repeat (SM * T - 1) @(negedge clk);
    count16(c); check("R5 before first minute", c, 2);
    @(negedge clk);
    count16(c); check("R5 after first minute", c, 1);
    repeat (SM * T - 1) @(negedge clk);
    check("R5 no early expiry", flag16, 0);
    @(negedge clk);
    count16(c); check("R5 expired count", c, 0);
    check("R5 flag", flag16, 1);
    check("R5 kbd pulse", kbd16, 1);
    wr(8'h71, 8'h01);

    // R9 expiry and clear on the same edge
    wr(8'h72, 8'h80);
    load(1);
    repeat (T - 2) @(negedge clk);
    wr(8'h71, 8'h01);
    check("R9 expiry beats clear", flag16, 1);
    wr(8'h71, 8'h01);
    check("R9 later clear", flag16, 0);

    // R12 reload on a tick edge
    load(5);
    repeat (T - 2) @(negedge clk);
    wr(8'h73, 8'd5);
    count16(c); check("R12 load wins", c, 5);
    repeat (T - 1) @(negedge clk);
    count16(c); check("R12 full period held", c, 5);
    @(negedge clk);
    count16(c); check("R12 next decrement", c, 4);

    // R7 keep-alive restart
    load(3);
    repeat (2 * T + 1) @(negedge clk);
    count16(c); check("R7 before reload", c, 1);
    wr(8'h73, 8'd3);
    count16(c); check("R7 reloaded", c, 3);
    repeat (3 * T - 1) @(negedge clk);
    check("R7 no expiry yet", flag16, 0);
    @(negedge clk);
    check("R7 expiry after restart", flag16, 1);
    wr(8'h71, 8'h01);

    // R6 zero stops
    load(5);
    repeat (T) @(negedge clk);
    wr(8'h73, 8'd0);
    count16(c); check("R6 stopped count", c, 0);
    repeat (10 * T) @(negedge clk);
    count16(c); check("R6 still zero", c, 0);
    check("R6 no timeout", {flag16, kbd16, tmo16, pwr16}, 0);

    // R3 R11 16-bit vs 8-bit assembly
    wr(8'h71, 8'h01);
    load(16'h0102);
    rd(8'h73, a, b); check("R3 lo 16", a, 8'h02); check("R11 lo 8", b, 8'h02);
    rd(8'h74, a, b); check("R3 hi 16", a, 8'h01); check("R11 hi ignored", b, 8'h00);
    repeat (2 * T) @(negedge clk);
    rd(8'h71, a, b);
    check("R11 narrow expired", b, 1);
    check("R3 wide running", a, 0);
    count16(c); check("R3 wide count", c, 16'h0100);
    load(0);
    count16(c); check("R6 stop wide", c, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule